// File: doc/BRIEF.md
# ULPI Link Register and Status Controller

This block sits on the link side of an 8-bit ULPI bus that joins local logic to a USB PHY. Local logic hands it one register access at a time: a write (address plus data) or a read (address). The block encodes the command byte and follows the PHY's `nxt` handshake through the command, any extended-address byte and the data. It ends a write with a one-cycle stop pulse. For a read, it waits out the bus turnaround and returns the byte the PHY puts on the bus.

It watches the direction signal at all times. The link drives the bus only when both the live direction and its one-cycle-delayed copy are low, so that every direction change leaves one turnaround cycle. While the PHY owns the bus, it can send status bytes, shown by direction high with next low. The block keeps the most recent status byte and decodes it into line state, bus-voltage state, receive-event flags, ID and an alternate-interrupt bit. If the PHY takes the bus while a command is still pending, the command is abandoned. It is driven again from its first byte once the bus comes back.

Packet transmit and receive streaming are not handled here. When no access is pending, the link drives the no-operation value.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While reset is held, the block does not drive the bus (`phy_oe` low), `phy_stp` is low, `done` is low, `req_ready` is high and all decoded status outputs are zero.
- R2: While no access is in progress and the link owns the bus, the data output is 0x00 (no-operation).
- R3: `phy_oe` is high only when `phy_dir` is low in the current cycle and was also low in the previous cycle. This leaves one cycle on which neither side drives the bus after each edge of `phy_dir`.
- R4: For an address from 0x00 to 0x2E, the command byte is {2'b10, addr[5:0]} for a write and {2'b11, addr[5:0]} for a read. It stays on the bus until a cycle in which `phy_nxt` is high and the link owns the bus.
- R5: For an address of 0x2F or higher, bits 5:0 of the command byte are 6'b101111. After the PHY accepts the command with `phy_nxt`, the full 8-bit address is driven and held until `phy_nxt` accepts it.
- R6: In a write, the data byte follows the accepted command or address and is held until `phy_nxt`. In the next cycle `phy_stp` is high for exactly one cycle with the bus at 0x00, and `done` pulses in the cycle after that.
- R7: In a read, after the command (or address) is accepted, the block waits for `phy_dir` to rise. It skips the turnaround cycle and captures `phy_din` on the first cycle with `phy_dir` high in two consecutive cycles and `phy_nxt` low. That byte appears on `rd_data`, with `done` high, in the following cycle.
- R8: If `phy_dir` rises while a command, an address or write data is pending, the access restarts from its command byte once the link owns the bus again.
- R9: A byte seen with `phy_dir` high in the current and the previous cycle, and `phy_nxt` low, outside the data cycle of a read, is taken as status. From the next cycle, bits 1:0 appear on `line_state` (bit 0 = D+, bit 1 = D-), bits 3:2 on `vbus_state`, bit 6 on `id_dig` and bit 7 on `alt_int`. Bytes seen on a turnaround cycle are not taken.
- R10: Receive-event bits 5:4 of the status byte are decoded as follows: 00 means none, 01 means `rx_active`, 11 means `rx_active` and `rx_error`, and 10 means `host_disc`.
- R11: A byte seen while `phy_dir` and `phy_nxt` are both high is packet data and leaves every status output unchanged.
- R12: `req_ready` is high only while no access is in progress. A request is taken in a cycle where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_dir | input | 1 | Bus direction from the PHY (high: PHY drives) |
| phy_nxt | input | 1 | PHY next / accept strobe |
| phy_din | input | 8 | Data bus as seen by the link |
| phy_dout | output | 8 | Data the link puts on the bus |
| phy_oe | output | 1 | Link output enable for the data bus |
| phy_stp | output | 1 | Stop pulse that ends a write |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle pulse when an access completes |
| rd_data | output | 8 | Byte returned by the last read |
| line_state | output | 2 | Decoded line state (bit 0 D+, bit 1 D-) |
| vbus_state | output | 2 | Encoded bus-voltage state |
| rx_active | output | 1 | Receive active |
| rx_error | output | 1 | Receive error |
| host_disc | output | 1 | Host disconnect |
| id_dig | output | 1 | ID pin state |
| alt_int | output | 1 | Alternate (non-USB) interrupt |

## Verification
The bench runs a write and a read at every one of the 256 addresses, with varying `nxt` stalls. A design with an off-by-one boundary between immediate and extended addressing would send the wrong command byte at 0x2E or 0x2F. A design that moved on without `nxt` would drop the held byte early. A read that sampled on the turnaround cycle would return the filler value instead of the PHY's byte.

All 256 status values are decoded and compared with fields computed in the bench. Packet bytes (`nxt` high) and turnaround bytes are sent to expose a decoder that takes them as status. The PHY takes the bus in the middle of a command and in the middle of write data: a controller without restart would finish with a stop pulse that was never earned, or would fail to send the command byte again.

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl #(
  parameter int DW = 8,
  parameter int IMM_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phy_dir,
  input  logic          phy_nxt,
  input  logic [DW-1:0] phy_din,
  output logic [DW-1:0] phy_dout,
  output logic          phy_oe,
  output logic          phy_stp,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    line_state,
  output logic [1:0]    vbus_state,
  output logic          rx_active,
  output logic          rx_error,
  output logic          host_disc,
  output logic          id_dig,
  output logic          alt_int
);
  localparam logic [IMM_W-1:0] EXT_CODE = {IMM_W{1'b1}} ^ IMM_W'(6'h10);
  localparam logic [DW-1:0]    IMM_LAST = DW'(EXT_CODE) - 1'b1;
  localparam logic [1:0]       K_WR = 2'b10;
  localparam logic [1:0]       K_RD = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_EXT, S_WDATA, S_STP, S_RTA} st_t;

  st_t st;
  logic dir_q, wr_q, own, ext;
  logic [DW-1:0] addr_q, wdat_q, stat_q, cmd_byte;

  assign own      = !phy_dir && !dir_q;
  assign ext      = addr_q > IMM_LAST;
  assign cmd_byte = {wr_q ? K_WR : K_RD, ext ? EXT_CODE : addr_q[IMM_W-1:0]};

  always_comb begin
    case (st)
      S_CMD:   phy_dout = cmd_byte;
      S_EXT:   phy_dout = addr_q;
      S_WDATA: phy_dout = wdat_q;
      default: phy_dout = '0;
    endcase
  end

  assign phy_oe    = own;
  assign phy_stp   = (st == S_STP);
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dir_q   <= 1'b1;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rd_data <= '0;
      stat_q  <= '0;
      done    <= 1'b0;
    end else begin
      dir_q <= phy_dir;
      done  <= 1'b0;
      if (phy_dir && dir_q && !phy_nxt && st != S_RTA)
        stat_q <= phy_din;
      case (st)
        S_IDLE:
          if (req_valid) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            wdat_q <= req_wdata;
            st     <= S_CMD;
          end
        S_CMD:
          if (own && phy_nxt)
            st <= ext ? S_EXT : (wr_q ? S_WDATA : S_RTA);
        S_EXT:
          if (phy_dir || dir_q) st <= S_CMD;
          else if (phy_nxt)     st <= wr_q ? S_WDATA : S_RTA;
        S_WDATA:
          if (phy_dir || dir_q) st <= S_CMD;
          else if (phy_nxt)     st <= S_STP;
        S_STP: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        S_RTA:
          if (phy_dir && dir_q) begin
            if (!phy_nxt) begin
              rd_data <= phy_din;
              done    <= 1'b1;
              st      <= S_IDLE;
            end else begin
              st <= S_CMD;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign line_state = stat_q[1:0];
  assign vbus_state = stat_q[3:2];
  assign rx_active  = stat_q[4];
  assign rx_error   = stat_q[5] && stat_q[4];
  assign host_disc  = stat_q[5] && !stat_q[4];
  assign id_dig     = stat_q[6];
  assign alt_int    = stat_q[7];

  p_oe_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_oe |-> (!phy_dir && !$past(phy_dir)));
  p_noop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (phy_dout == '0));
  p_stp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_stp |=> (!phy_stp && done));
  p_stp_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_stp |-> (phy_dout == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_oe && !phy_nxt && !req_ready && !phy_stp) |=> $stable(phy_dout));
  p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phy_stp) || ($past(phy_dir) && !$past(phy_nxt))));
  p_pkt_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_dir && phy_nxt) |=> $stable({line_state, vbus_state, rx_active, rx_error, host_disc, id_dig, alt_int}));
  p_turn_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_dir) |=> $stable({line_state, vbus_state, id_dig, alt_int}));
  p_ev_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_disc, rx_active}) && (!rx_error || rx_active));
endmodule

// File: tb/ulpi_link_ctrl_tb.sv
module ulpi_link_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phy_dir = 1'b0, phy_nxt = 1'b0;
  logic [7:0] phy_din = 8'h00;
  logic [7:0] phy_dout;
  logic phy_oe, phy_stp;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic req_ready, done;
  logic [7:0] rd_data;
  logic [1:0] line_state, vbus_state;
  logic rx_active, rx_error, host_disc, id_dig, alt_int;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_link_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .phy_dir(phy_dir), .phy_nxt(phy_nxt),
    .phy_din(phy_din), .phy_dout(phy_dout), .phy_oe(phy_oe), .phy_stp(phy_stp),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .line_state(line_state), .vbus_state(vbus_state), .rx_active(rx_active),
    .rx_error(rx_error), .host_disc(host_disc), .id_dig(id_dig), .alt_int(alt_int)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] stat_vec();
    return {line_state, vbus_state, rx_active, rx_error, host_disc, id_dig, alt_int};
  endfunction

  function automatic logic [9:0] exp_stat(input int b);
    int ev;
    ev = (b / 16) % 4;
    return {2'(b % 4), 2'((b / 4) % 4), ev == 1 || ev == 3, ev == 3, ev == 2,
            1'((b / 64) % 2), 1'(b / 128)};
  endfunction

  function automatic logic [7:0] exp_cmd(input bit wr, input int a);
    int low;
    low = (a > 46) ? 47 : a % 64;
    return 8'((wr ? 128 : 192) + low);
  endfunction

  task automatic xfer(input bit wr, input int a, input logic [7:0] d, input int w);
    logic [7:0] c;
    logic [9:0] s0;
    c = exp_cmd(wr, a);
    s0 = stat_vec();
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 8'(a); req_wdata = wr ? d : 8'hFF;
    #1 chk(req_ready, "R12 ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; phy_nxt = 1'b0;
    #1 chk(!req_ready, "R12 busy", req_ready, 0);
    for (int i = 0; i < w; i++) begin
      chk(phy_oe && phy_dout == c, "R4 command held", phy_dout, c);
      @(negedge clk);
    end
    phy_nxt = 1'b1;
    #1 chk(phy_oe && phy_dout == c, "R4 R5 command byte", phy_dout, c);
    if (a > 46) begin
      @(negedge clk);
      #1 chk(phy_dout == 8'(a), "R5 extended address", phy_dout, a);
    end
    if (wr) begin
      @(negedge clk);
      phy_nxt = 1'b0;
      #1 chk(phy_dout == d && !phy_stp, "R6 data held", phy_dout, d);
      @(negedge clk);
      phy_nxt = 1'b1;
      #1 chk(phy_dout == d, "R6 data byte", phy_dout, d);
      @(negedge clk);
      phy_nxt = 1'b0;
      #1 chk(phy_stp && phy_dout == 8'h00, "R6 stop pulse", {phy_stp, phy_dout}, 9'h100);
      @(negedge clk);
      #1 chk(done && !phy_stp, "R6 done after stop", {done, phy_stp}, 2'b10);
    end else begin
      @(negedge clk);
      phy_nxt = 1'b0; phy_dir = 1'b1; phy_din = 8'hEE;
      #1 chk(!phy_oe, "R3 turnaround", phy_oe, 0);
      @(negedge clk);
      phy_din = d;
      #1 chk(!phy_oe && !done, "R7 no early sample", {phy_oe, done}, 0);
      @(negedge clk);
      phy_dir = 1'b0; phy_din = 8'h00;
      #1 chk(done && rd_data == d, "R7 read data", rd_data, d);
      chk(!phy_oe, "R3 turnaround after dir fall", phy_oe, 0);
      chk(stat_vec() == s0, "R9 read data not status", stat_vec(), s0);
      @(negedge clk);
      #1 chk(phy_oe && phy_dout == 8'h00 && !done, "R2 idle noop", phy_dout, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] c;
    logic [9:0] s;
    repeat (3) @(negedge clk);
    #1 chk(!phy_oe && !phy_stp && !done && req_ready, "R1 reset outputs",
           {phy_oe, phy_stp, done, req_ready}, 4'b0001);
    chk(stat_vec() == 10'd0, "R1 reset status", stat_vec(), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(phy_oe && phy_dout == 8'h00, "R2 noop after reset", phy_dout, 0);

    for (int a = 0; a < 256; a++) begin
      xfer(1'b1, a, 8'(a) ^ 8'h5A, a % 3);
      xfer(1'b0, a, ~8'(a), a % 2);
    end

    // status sweep R9 R10, packet bytes R11
    @(negedge clk);
    phy_dir = 1'b1; phy_din = 8'hFF;
    s = stat_vec();
    #1 chk(!phy_oe, "R3 dir rise", phy_oe, 0);
    @(posedge clk);
    #1 chk(stat_vec() == s, "R9 turnaround byte ignored", stat_vec(), s);
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      phy_nxt = 1'b0; phy_din = 8'(b);
      @(posedge clk);
      #1 chk(stat_vec() == exp_stat(b), "R9 R10 status decode", stat_vec(), exp_stat(b));
      @(negedge clk);
      phy_nxt = 1'b1; phy_din = ~8'(b);
      @(posedge clk);
      #1 chk(stat_vec() == exp_stat(b), "R11 packet byte ignored", stat_vec(), exp_stat(b));
    end
    @(negedge clk);
    phy_nxt = 1'b0; phy_dir = 1'b0; phy_din = 8'h00;
    @(negedge clk);

    // abort while command pending R8
    c = exp_cmd(1'b1, 4);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 8'h45;
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk(phy_dout == c, "R4 command before abort", phy_dout, c);
    @(negedge clk);
    phy_dir = 1'b1; phy_din = 8'hAA; phy_nxt = 1'b1;
    #1 chk(!phy_oe, "R3 PHY takes bus", phy_oe, 0);
    @(negedge clk);
    phy_nxt = 1'b0; phy_din = 8'h19;
    @(negedge clk);
    phy_dir = 1'b0; phy_din = 8'h00;
    #1 chk(!phy_oe, "R3 turnaround", phy_oe, 0);
    chk(stat_vec() == exp_stat(8'h19), "R9 status during abort", stat_vec(), exp_stat(8'h19));
    @(negedge clk);
    #1 chk(phy_oe && phy_dout == c, "R8 command retried", phy_dout, c);
    phy_nxt = 1'b1;
    @(negedge clk);
    phy_nxt = 1'b0;
    #1 chk(phy_dout == 8'h45, "R6 data after retry", phy_dout, 8'h45);
    // abort during write data
    @(negedge clk);
    phy_dir = 1'b1;
    @(negedge clk);
    #1 chk(!phy_stp, "R8 no stop on abort", phy_stp, 0);
    @(negedge clk);
    phy_dir = 1'b0;
    @(negedge clk);
    #1 chk(phy_oe && phy_dout == c && !phy_stp, "R8 restart from command", phy_dout, c);
    phy_nxt = 1'b1;
    @(negedge clk);
    #1 chk(phy_dout == 8'h45, "R6 data byte again", phy_dout, 8'h45);
    @(negedge clk);
    phy_nxt = 1'b0;
    #1 chk(phy_stp && phy_dout == 8'h00, "R6 stop after retry", phy_stp, 1);
    @(negedge clk);
    #1 chk(done && req_ready, "R6 R12 done and idle", {done, req_ready}, 2'b11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule